// File: doc/BRIEF.md
# Bit-Sliced Arithmetic/Logic Unit

This block is a combinational arithmetic/logic unit. It is built from identical one-bit slices chained through a ripple carry. Each slice sees one bit of each operand, the carry from the slice below it, a two-bit operation code and two operand enables. It returns one result bit and a carry for the slice above it. The operation code is decoded into four one-hot select lines. These pick between bitwise AND, bitwise OR, inversion of the second operand, and a full-adder sum.

Each operand enable gates its operand to zero when low. A carry injection input feeds the least significant slice. Together these let the adder compute the first operand plus one without a stored constant: set the operation to add, drop the second operand's enable, and raise the carry injection. The width is a parameter with a default of 8. A second parameter chooses whether each slice decodes the operation code itself or all slices share one decoder.

Top module: `bitslice_alu`

## Requirements
- R1: The operation code selects exactly one of four operations, encoded 00 = AND, 01 = OR, 10 = NOT of the second operand, 11 = ADD. In every slice exactly one of the four select lines is active.
- R2: For codes 00 and 01 the result is the bitwise AND or OR of the gated operands, and the final carry is 0 whatever the carry injection is.
- R3: For code 10 the result is the bitwise inverse of the gated second operand, and the final carry is 0.
- R4: For code 11, {carry, result} equals the gated first operand plus the gated second operand plus the carry injection. The carry ripples from slice i to slice i+1.
- R5: When the first operand's enable is low, the first operand is treated as all zeros for every operation.
- R6: When the second operand's enable is low, the second operand is treated as all zeros. With ADD and the carry injection set, the result is the first operand plus one, and the carry is 1 only when the first operand is all ones.
- R7: With all inputs at zero, the result is 0 and the carry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| fn | input | 2 | Operation code (00 AND, 01 OR, 10 NOT B, 11 ADD) |
| ena | input | 1 | Enable for the first operand; low forces it to zero |
| enb | input | 1 | Enable for the second operand; low forces it to zero |
| inc | input | 1 | Carry injected into the least significant slice |
| res | output | WIDTH | Result |
| cout | output | 1 | Carry out of the most significant slice (ADD only) |

## Verification
The hardest case to reach is a carry that ripples through every slice. Only operand pairs whose gated sum is exactly all ones, with the carry injection set, or the first operand at all ones while the second is disabled, make the top slice depend on bit 0. The stimulus sweeps every pair of 8-bit operands under every operation code, so all such pairs are covered. A second sweep walks every enable and injection combination over the full range of the first operand, which covers the increment-from-all-ones wrap. Expected values come from integer arithmetic in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [1:0] {
      OP_AND = 2'b00,
      OP_OR  = 2'b01,
      OP_NOTB = 2'b10,
      OP_ADD = 2'b11
   } alu_op_e;

   localparam int unsigned NUM_OPS = 4;

   typedef logic [NUM_OPS-1:0] op_sel_t;

   localparam int unsigned SEL_AND  = 0;
   localparam int unsigned SEL_OR   = 1;
   localparam int unsigned SEL_NOTB = 2;
   localparam int unsigned SEL_ADD  = 3;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
   import alu_pkg::*;
(
   input  logic [1:0] op_code,
   output op_sel_t    op_sel
);

   always_comb begin
      op_sel = '0;
      unique case (alu_op_e'(op_code))
         OP_AND:  op_sel[SEL_AND]  = 1'b1;
         OP_OR:   op_sel[SEL_OR]   = 1'b1;
         OP_NOTB: op_sel[SEL_NOTB] = 1'b1;
         OP_ADD:  op_sel[SEL_ADD]  = 1'b1;
         default: op_sel = '0;
      endcase
   end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
   import alu_pkg::*;
(
   input  logic    a_bit,
   input  logic    b_bit,
   input  logic    a_en,
   input  logic    b_en,
   input  logic    c_in,
   input  op_sel_t sel,
   output logic    y_bit,
   output logic    c_out
);

   logic a_g;
   logic b_g;
   logic half;
   logic sum;
   logic gen;

   assign a_g  = a_bit & a_en;
   assign b_g  = b_bit & b_en;
   assign half = a_g ^ b_g;
   assign sum  = half ^ c_in;
   assign gen  = (a_g & b_g) | (c_in & half);

   always_comb begin
      y_bit = (sel[SEL_AND]  & (a_g & b_g))
            | (sel[SEL_OR]   & (a_g | b_g))
            | (sel[SEL_NOTB] & ~b_g)
            | (sel[SEL_ADD]  & sum);
      c_out = sel[SEL_ADD] & gen;
   end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
   import alu_pkg::*;
#(
   parameter int unsigned WIDTH         = 8,
   parameter bit          SHARED_DECODE = 1'b0
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [1:0]       fn,
   input  logic             ena,
   input  logic             enb,
   input  logic             inc,
   output logic [WIDTH-1:0] res,
   output logic             cout
);

   localparam int unsigned CHAIN = WIDTH + 1;

   if (WIDTH < 1) begin : g_width_chk
      $error("bitslice_alu: WIDTH must be at least 1");
   end

   logic [CHAIN-1:0]          carry;
   op_sel_t [WIDTH-1:0]       sel_lines;

   assign carry[0] = inc;

   if (SHARED_DECODE) begin : g_shared_dec
      op_sel_t common_sel;
      alu_op_decode u_dec (
         .op_code (fn),
         .op_sel  (common_sel)
      );
      for (genvar s = 0; s < WIDTH; s++) begin : g_fan
         assign sel_lines[s] = common_sel;
      end
   end else begin : g_local_dec
      for (genvar s = 0; s < WIDTH; s++) begin : g_dec
         alu_op_decode u_dec (
            .op_code (fn),
            .op_sel  (sel_lines[s])
         );
      end
   end

   for (genvar s = 0; s < WIDTH; s++) begin : g_slice
      alu_slice u_slice (
         .a_bit (opa[s]),
         .b_bit (opb[s]),
         .a_en  (ena),
         .b_en  (enb),
         .c_in  (carry[s]),
         .sel   (sel_lines[s]),
         .y_bit (res[s]),
         .c_out (carry[s+1])
      );
   end

   assign cout = carry[CHAIN-1];

endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk
   import alu_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input logic [WIDTH-1:0]    opa,
   input logic [WIDTH-1:0]    opb,
   input logic [1:0]          fn,
   input logic                ena,
   input logic                enb,
   input logic                inc,
   input logic [WIDTH-1:0]    res,
   input logic                cout,
   input op_sel_t [WIDTH-1:0] sel_lines
);

   logic [WIDTH-1:0] ga;
   logic [WIDTH-1:0] gb;
   logic [WIDTH:0]   total;

   assign ga    = ena ? opa : '0;
   assign gb    = enb ? opb : '0;
   assign total = {1'b0, ga} + {1'b0, gb} + {{WIDTH{1'b0}}, inc};

   always_comb begin
      for (int s = 0; s < WIDTH; s++) begin
         p_sel_onehot_r1: assert ($onehot(sel_lines[s]))
            else $error("select lines of slice %0d not one-hot", s);
      end
      if (fn != 2'b11) begin
         p_logic_nocarry_r2: assert (cout == 1'b0)
            else $error("carry set for a logic operation");
      end
      if (fn == 2'b10) begin
         p_notb_r3: assert (res == ~gb)
            else $error("NOT B result mismatch");
      end
      if (fn == 2'b11) begin
         p_add_sum_r4: assert ({cout, res} == total)
            else $error("ADD result mismatch");
      end
      if (!ena && fn == 2'b00) begin
         p_ena_gate_r5: assert (res == '0)
            else $error("first operand not gated");
      end
      if (!enb && inc && fn == 2'b11) begin
         p_increment_r6: assert ({cout, res} == ({1'b0, ga} + 1'b1))
            else $error("increment mismatch");
      end
   end

endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .opa       (opa),
   .opb       (opb),
   .fn        (fn),
   .ena       (ena),
   .enb       (enb),
   .inc       (inc),
   .res       (res),
   .cout      (cout),
   .sel_lines (sel_lines)
);

// File: tb/tb_bitslice_alu.sv
`timescale 1ns/1ps
module tb_bitslice_alu;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic [1:0]   fn = 2'b00;
   logic         ena = 1'b0;
   logic         enb = 1'b0;
   logic         inc = 1'b0;
   logic [W-1:0] res;
   logic         cout;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bitslice_alu #(.WIDTH(W)) dut (
      .opa  (opa),
      .opb  (opb),
      .fn   (fn),
      .ena  (ena),
      .enb  (enb),
      .inc  (inc),
      .res  (res),
      .cout (cout)
   );

   function automatic logic [W:0] model(input int a, input int b, input int f,
                                        input bit ea, input bit eb, input bit ci);
      int ga;
      int gb;
      int r;
      ga = ea ? a : 0;
      gb = eb ? b : 0;
      case (f)
         0: r = ga & gb;
         1: r = ga | gb;
         2: r = (~gb) & ((1 << W) - 1);
         default: r = ga + gb + int'(ci);
      endcase
      return r[W:0];
   endfunction

   task automatic apply_check(input int a, input int b, input int f,
                              input bit ea, input bit eb, input bit ci,
                              input string req);
      logic [W:0] exp_v;
      opa = a[W-1:0];
      opb = b[W-1:0];
      fn  = f[1:0];
      ena = ea;
      enb = eb;
      inc = ci;
      #1;
      exp_v = model(a, b, f, ea, eb, ci);
      total++;
      if ({cout, res} !== exp_v) begin
         bad++;
         if (bad < 20)
            $display("FAIL %s: fn=%0d a=%0d b=%0d ena=%0b enb=%0b inc=%0b actual=%0h expected=%0h",
                     req, f, a, b, ea, eb, ci, {cout, res}, exp_v);
      end
      #1;
   endtask

   initial begin
      #0.3;
      #20 rst_n = 1'b1;
      // R7: all-zero inputs
      apply_check(0, 0, 0, 1'b0, 1'b0, 1'b0, "R7");
      // R1 R2 R3 R4: full operand sweep under each code, both enables high
      for (int f = 0; f < 4; f++) begin
         for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
               apply_check(a, b, f, 1'b1, 1'b1, bit'((a ^ b) & 1),
                           f == 3 ? "R4" : (f == 2 ? "R3" : "R2"));
            end
         end
      end
      // R5 R6: every enable and injection combination, every first operand
      for (int f = 0; f < 4; f++) begin
         for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < (1 << W); a++) begin
               for (int b = 0; b < (1 << W); b += 37) begin
                  apply_check(a, b, f, bit'(m & 1), bit'((m >> 1) & 1), bit'((m >> 2) & 1),
                              (m & 1) == 0 ? "R5" : "R6");
               end
            end
         end
      end
      // R6: increment wrap from all ones
      apply_check((1 << W) - 1, 5, 3, 1'b1, 1'b0, 1'b1, "R6");
      apply_check(0, 0, 3, 1'b1, 1'b0, 1'b1, "R6");
      // R2: logic codes ignore the injected carry
      apply_check((1 << W) - 1, (1 << W) - 1, 0, 1'b1, 1'b1, 1'b1, "R2");
      apply_check((1 << W) - 1, 0, 1, 1'b1, 1'b1, 1'b1, "R2");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule